// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block sits between the internal logic array and a single bidirectional pin. It holds three flip-flops: one captures the pin value, one holds output data and one holds the output enable. The pin is modelled as three separate signals (`pad_in`, `pad_out` and `pad_oe`), so no tristate primitive is needed. Two selectors choose the path for the output data and for the drive enable. Each selector picks either the value coming straight from the array or the value held in its register.

Static configuration inputs set four things: the direction, the output polarity, whether the drive is forced off, and which path each selector takes. The array always receives the raw pin value and the captured pin value as two separate outputs. It also receives the output register's content as a feedback value. When the drive is disabled, the output register can therefore serve as a plain storage element. The configuration inputs are assumed static during operation.

Top module: `bpc_pad_cell`

## Requirements
- R1: `core_din_comb` equals `pad_in` in the same cycle, whatever the configuration.
- R2: On a rising `clk` edge with `in_ce` high, the capture register loads `pad_in`. `core_din_reg` shows its content.
- R3: `cfg_out_reg`=0 sends `core_dout` straight to the polarity stage. `cfg_out_reg`=1 sends the output register instead, which loads `core_dout` on a rising edge with `out_ce` high.
- R4: `cfg_oe_reg`=0 uses `core_oe` as the selected enable. `cfg_oe_reg`=1 uses the enable register instead, which loads `core_oe` on a rising edge with `oe_ce` high.
- R5: Polarity `cfg_pol`=2'b00 (active high) drives `pad_out` equal to the selected data. `cfg_pol`=2'b01 (active low) drives its inverse. Code 2'b11 acts as active high.
- R6: Polarity `cfg_pol`=2'b10 (open-drain inverting) holds `pad_out` at 0. `pad_oe` is then high only when the selected data is 1 and the drive is otherwise allowed, so the cell never drives a 1.
- R7: Direction `cfg_dir`=2'b01 (output only) ignores the selected enable. The drive is then always on, except where R6 or R9 turn it off.
- R8: Direction `cfg_dir`=2'b00 (input only) holds `pad_oe` at 0. Codes 2'b10 and 2'b11 are bidirectional and use the selected enable.
- R9: `cfg_oe_off`=1 holds `pad_oe` at 0. The output register still loads, and `core_fb_out` always shows its content.
- R10: Each register holds its value on any edge where its own clock enable is low, independently of the other two enables.
- R11: `rst` high clears all three registers to 0 at once, without waiting for a clock edge. With the enable register selected, the pin is then not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the three registers |
| rst | input | 1 | Asynchronous active-high reset |
| cfg_dir | input | 2 | Direction: 00 input only, 01 output only, 10/11 bidirectional |
| cfg_pol | input | 2 | Polarity: 00 active high, 01 active low, 10 open-drain inverting, 11 active high |
| cfg_oe_off | input | 1 | Forces the drive off |
| cfg_out_reg | input | 1 | Selects the registered data path |
| cfg_oe_reg | input | 1 | Selects the registered enable path |
| core_dout | input | 1 | Output data from the array |
| core_oe | input | 1 | Drive enable from the array |
| in_ce | input | 1 | Clock enable of the capture register |
| out_ce | input | 1 | Clock enable of the output register |
| oe_ce | input | 1 | Clock enable of the enable register |
| pad_in | input | 1 | Value seen on the pin |
| pad_out | output | 1 | Value driven onto the pin |
| pad_oe | output | 1 | Pin drive enable |
| core_din_comb | output | 1 | Raw pin value to the array |
| core_din_reg | output | 1 | Captured pin value to the array |
| core_fb_out | output | 1 | Output register content fed back to the array |

## Verification
The cell has two kinds of result, and each is due at a different time:
- **Direct paths:** `core_din_comb` and, with the direct selectors, `pad_out` and `pad_oe` are combinational. They are due in the same cycle as the stimulus. The bench drives them at the falling edge and samples before the next rising edge.
- **Register contents:** every value that passes through a register appears one rising edge after its clock enable was sampled high. The bench drives at the falling edge, waits for the rising edge, and samples one nanosecond later.

Reset is asynchronous, so its effect is checked shortly after `rst` rises, with no clock edge in between.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [1:0] {
        DIR_IN_ONLY  = 2'b00,
        DIR_OUT_ONLY = 2'b01,
        DIR_BIDIR    = 2'b10,
        DIR_BIDIR_X  = 2'b11
    } dir_mode_e;

    typedef enum logic [1:0] {
        POL_HIGH   = 2'b00,
        POL_LOW    = 2'b01,
        POL_OD_INV = 2'b10,
        POL_HIGH_X = 2'b11
    } pol_mode_e;

endpackage

// File: rtl/bpc_cell_reg.sv
module bpc_cell_reg #(
    parameter int          WIDTH     = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (ce) begin
            q <= d;
        end
    end

    // R10
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));

    // R2
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> (q == $past(d)));

endmodule

// File: rtl/bpc_path_sel.sv
module bpc_path_sel #(
    parameter int WIDTH = 1
) (
    input  logic             use_reg,
    input  logic [WIDTH-1:0] direct_val,
    input  logic [WIDTH-1:0] reg_val,
    output logic [WIDTH-1:0] sel_val
);

    always_comb begin
        sel_val = use_reg ? reg_val : direct_val;
    end

endmodule

// File: rtl/bpc_drive_ctl.sv
module bpc_drive_ctl
    import bpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dir_mode_e dir_mode,
    input  pol_mode_e pol_mode,
    input  logic      force_off,
    input  logic      data_sel,
    input  logic      en_sel,
    output logic      pad_out,
    output logic      pad_oe
);

    logic dir_en;
    logic pol_en;

    always_comb begin
        unique case (dir_mode)
            DIR_IN_ONLY:  dir_en = 1'b0;
            DIR_OUT_ONLY: dir_en = 1'b1;
            DIR_BIDIR:    dir_en = en_sel;
            DIR_BIDIR_X:  dir_en = en_sel;
            default:      dir_en = 1'b0;
        endcase
    end

    always_comb begin
        unique case (pol_mode)
            POL_HIGH: begin
                pad_out = data_sel;
                pol_en  = 1'b1;
            end
            POL_LOW: begin
                pad_out = ~data_sel;
                pol_en  = 1'b1;
            end
            POL_OD_INV: begin
                pad_out = 1'b0;
                pol_en  = data_sel;
            end
            POL_HIGH_X: begin
                pad_out = data_sel;
                pol_en  = 1'b1;
            end
            default: begin
                pad_out = data_sel;
                pol_en  = 1'b1;
            end
        endcase
    end

    always_comb begin
        pad_oe = dir_en & pol_en & ~force_off;
    end

    // R6
    od_never_high_chk: assert property (@(posedge clk) disable iff (rst)
        (pol_mode == POL_OD_INV && pad_oe) |-> !pad_out);

    // R8
    in_only_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_mode == DIR_IN_ONLY) |-> !pad_oe);

    // R9
    forced_off_chk: assert property (@(posedge clk) disable iff (rst)
        force_off |-> !pad_oe);

    // R7
    out_only_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_mode == DIR_OUT_ONLY && !force_off && pol_mode != POL_OD_INV) |-> pad_oe);

endmodule

// File: rtl/bpc_pad_cell.sv
module bpc_pad_cell
    import bpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_dir,
    input  logic [1:0] cfg_pol,
    input  logic       cfg_oe_off,
    input  logic       cfg_out_reg,
    input  logic       cfg_oe_reg,
    input  logic       core_dout,
    input  logic       core_oe,
    input  logic       in_ce,
    input  logic       out_ce,
    input  logic       oe_ce,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       core_din_comb,
    output logic       core_din_reg,
    output logic       core_fb_out
);

    localparam int LANE_W = 1;

    logic [LANE_W-1:0] in_q;
    logic [LANE_W-1:0] out_q;
    logic [LANE_W-1:0] oe_q;
    logic [LANE_W-1:0] data_sel;
    logic [LANE_W-1:0] en_sel;

    bpc_cell_reg #(.WIDTH(LANE_W)) u_in_reg (
        .clk(clk), .rst(rst), .ce(in_ce), .d(pad_in), .q(in_q)
    );

    bpc_cell_reg #(.WIDTH(LANE_W)) u_out_reg (
        .clk(clk), .rst(rst), .ce(out_ce), .d(core_dout), .q(out_q)
    );

    bpc_cell_reg #(.WIDTH(LANE_W)) u_oe_reg (
        .clk(clk), .rst(rst), .ce(oe_ce), .d(core_oe), .q(oe_q)
    );

    bpc_path_sel #(.WIDTH(LANE_W)) u_data_sel (
        .use_reg(cfg_out_reg), .direct_val(core_dout), .reg_val(out_q), .sel_val(data_sel)
    );

    bpc_path_sel #(.WIDTH(LANE_W)) u_en_sel (
        .use_reg(cfg_oe_reg), .direct_val(core_oe), .reg_val(oe_q), .sel_val(en_sel)
    );

    bpc_drive_ctl u_drive (
        .clk      (clk),
        .rst      (rst),
        .dir_mode (dir_mode_e'(cfg_dir)),
        .pol_mode (pol_mode_e'(cfg_pol)),
        .force_off(cfg_oe_off),
        .data_sel (data_sel[0]),
        .en_sel   (en_sel[0]),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    always_comb begin
        core_din_comb = pad_in;
        core_din_reg  = in_q[0];
        core_fb_out   = out_q[0];
    end

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |-> (!core_din_reg && !core_fb_out));

    // R1
    raw_in_chk: assert property (@(posedge clk) disable iff (rst)
        core_din_comb == pad_in);

endmodule

// File: tb/bpc_pad_cell_tb_top.sv
`timescale 1ns/1ps
module bpc_pad_cell_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_dir;
    logic [1:0] cfg_pol;
    logic       cfg_oe_off, cfg_out_reg, cfg_oe_reg;
    logic       core_dout, core_oe, in_ce, out_ce, oe_ce, pad_in;
    logic       pad_out, pad_oe, core_din_comb, core_din_reg, core_fb_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bpc_pad_cell dut_i (
        .clk(clk), .rst(rst), .cfg_dir(cfg_dir), .cfg_pol(cfg_pol),
        .cfg_oe_off(cfg_oe_off), .cfg_out_reg(cfg_out_reg), .cfg_oe_reg(cfg_oe_reg),
        .core_dout(core_dout), .core_oe(core_oe), .in_ce(in_ce), .out_ce(out_ce),
        .oe_ce(oe_ce), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .core_din_comb(core_din_comb), .core_din_reg(core_din_reg), .core_fb_out(core_fb_out)
    );

    // {dir[1:0], pol[1:0], oe_off, dout, oe, exp_pad_out, exp_pad_oe}
    localparam logic [8:0] VEC [16] = '{
        9'b10_00_0_1_1_1_1,  // R5 active high
        9'b10_00_0_0_1_0_1,  // R5
        9'b10_00_0_1_0_1_0,  // R4 direct enable low
        9'b10_01_0_1_1_0_1,  // R5 active low
        9'b10_01_0_0_1_1_1,  // R5
        9'b10_10_0_1_1_0_1,  // R6 open drain pull
        9'b10_10_0_0_1_0_0,  // R6 open drain release
        9'b10_10_0_1_0_0_0,  // R6 enable low
        9'b01_00_0_1_0_1_1,  // R7 output only ignores enable
        9'b01_01_0_1_0_0_1,  // R7
        9'b01_10_0_0_0_0_0,  // R7 with R6
        9'b01_10_0_1_0_0_1,  // R7 with R6
        9'b00_00_0_1_1_1_0,  // R8 input only
        9'b00_10_0_1_1_0_0,  // R8
        9'b10_00_1_1_1_1_0,  // R9 forced off
        9'b01_00_1_1_1_1_0   // R9
    };

    task automatic check(input string req, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic edge_then_sample();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_dir = 2'b10; cfg_pol = 2'b00; cfg_oe_off = 1'b0;
        cfg_out_reg = 1'b0; cfg_oe_reg = 1'b0;
        core_dout = 1'b0; core_oe = 1'b0;
        in_ce = 1'b0; out_ce = 1'b0; oe_ce = 1'b0; pad_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        cfg_oe_reg = 1'b1;
        #1;
        check("R11 din_reg", core_din_reg, 1'b0);
        check("R11 fb_out", core_fb_out, 1'b0);
        check("R11 pad_oe", pad_oe, 1'b0);
        cfg_oe_reg = 1'b0;

        // vector table, direct paths
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            {cfg_dir, cfg_pol, cfg_oe_off, core_dout, core_oe} = VEC[i][8:2];
            #1;
            check($sformatf("R5-7 vec%0d pad_out", i), pad_out, VEC[i][1]);
            check($sformatf("R6-9 vec%0d pad_oe", i), pad_oe, VEC[i][0]);
        end

        // R1 and R2, R10: capture register
        @(negedge clk);
        cfg_dir = 2'b10; cfg_pol = 2'b00; cfg_oe_off = 1'b0;
        pad_in = 1'b1; in_ce = 1'b0;
        #1;
        check("R1 raw input", core_din_comb, 1'b1);
        edge_then_sample();
        check("R10 capture held", core_din_reg, 1'b0);
        @(negedge clk);
        in_ce = 1'b1;
        edge_then_sample();
        check("R2 capture load", core_din_reg, 1'b1);
        @(negedge clk);
        in_ce = 1'b0; pad_in = 1'b0;
        #1;
        check("R1 raw input low", core_din_comb, 1'b0);
        edge_then_sample();
        check("R10 capture held high", core_din_reg, 1'b1);

        // R3: registered data path
        @(negedge clk);
        cfg_out_reg = 1'b1; core_oe = 1'b1; core_dout = 1'b1; out_ce = 1'b1;
        #1;
        check("R3 before edge", pad_out, 1'b0);
        edge_then_sample();
        check("R3 reg data", pad_out, 1'b1);
        check("R9 feedback", core_fb_out, 1'b1);
        @(negedge clk);
        out_ce = 1'b0; core_dout = 1'b0;
        edge_then_sample();
        check("R10 out held", pad_out, 1'b1);

        // R4: registered enable path
        @(negedge clk);
        cfg_oe_reg = 1'b1; core_oe = 1'b1; oe_ce = 1'b0;
        #1;
        check("R4 reg en zero", pad_oe, 1'b0);
        @(negedge clk);
        oe_ce = 1'b1;
        edge_then_sample();
        check("R4 reg en load", pad_oe, 1'b1);
        @(negedge clk);
        oe_ce = 1'b0; core_oe = 1'b0;
        edge_then_sample();
        check("R10 en held", pad_oe, 1'b1);

        // R9: forced off, output register still loads
        @(negedge clk);
        cfg_oe_off = 1'b1; out_ce = 1'b1; core_dout = 1'b0;
        edge_then_sample();
        check("R9 pad_oe off", pad_oe, 1'b0);
        check("R9 fb loads", core_fb_out, 1'b0);
        @(negedge clk);
        core_dout = 1'b1;
        edge_then_sample();
        check("R9 fb loads high", core_fb_out, 1'b1);
        out_ce = 1'b0;

        // R11: asynchronous reset mid-cycle
        @(negedge clk);
        cfg_oe_off = 1'b0; pad_in = 1'b1; in_ce = 1'b1;
        edge_then_sample();
        check("R2 pre-reset capture", core_din_reg, 1'b1);
        #0.5;
        rst = 1'b1;
        #0.3;
        check("R11 async din_reg", core_din_reg, 1'b0);
        check("R11 async fb", core_fb_out, 1'b0);
        check("R11 async oe", pad_oe, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        in_ce = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule